// File: doc/BRIEF.md
# Audio bit and frame clock generator

This block produces the serial bit clock and the word-select (frame) clock for a stereo audio serial port. It runs in the master audio clock domain, and every `clk` cycle is one master clock period. In master mode it divides the master clock down to the bit clock by 2 or 4. It then divides the bit clock to the frame clock by 32, 64 or 128 bit periods per stereo frame. It drives both clocks out and raises `clk_drive_en` to enable the pin drivers.

In slave mode it takes both clocks from external pins. Each pin passes through a two-flop synchronizer, and the block regenerates the same clock outputs and strobes from the synchronized copies. In either mode the serializer receives single-cycle strobes for the data-launch edge, the data-capture edge and the start of each frame.

A polarity input selects which bit-clock edge launches data. A gating option parks the bit clock while no data moves. The clocks run only while the global enable is set and at least one of transmit or receive is enabled.

Top module: `acg_clkgen`

## Requirements
- R1: In master mode the bit period is 2 master cycles when `mdiv_sel`=0 and 4 when `mdiv_sel`=1. With `bclk_invert`=0, `bclk_o` is low for the first half of each bit period and high for the second.
- R2: `frame_sel` gives the frame length in bit periods: 0 gives 32, 1 gives 64, and 2 or 3 give 128. `ws_o` is low (left) for the first half of the frame and high (right) for the second, each half exactly half the frame.
- R3: `bclk_invert`=0 makes the launch edge falling and `bclk_invert`=1 makes it rising, which inverts `bclk_o`. `launch_stb` is high for the one cycle in which `bclk_o` first shows the launch level. `capture_stb` marks the opposite edge. The two strobes are never high together.
- R4: `frame_stb` is high in the cycle that starts bit 0 of the left half, together with `launch_stb` and with `ws_o` low.
- R5: The block runs only while `global_en`=1 and (`tx_en` or `rx_en`)=1. One cycle after it stops running, every counter is cleared and the outputs are idle: `bclk_o`=~`bclk_invert`, `ws_o`=0, all strobes 0.
- R6: The first output cycle after running starts is bit 0 of a left half. `frame_stb` and `launch_stb` are 1 and `ws_o` is 0 in that cycle.
- R7: In master mode with `free_run`=0 and `data_active`=0, `bclk_o` is held at the idle level ~`bclk_invert` while `ws_o` and the strobes keep their timing. With `free_run`=1 the bit clock always toggles.
- R8: In slave mode `ext_bclk` and `ext_ws` pass two synchronizer flops. `bclk_o` and `ws_o` follow them 3 cycles after a change. The launch or capture strobe, and `frame_stb` on a falling `ws`, appear in that same cycle for one cycle.
- R9: `clk_drive_en` is 1 exactly one cycle after a cycle in which the block runs in master mode, and 0 otherwise.
- R10: During synchronous reset the outputs take the idle values of R5 and `clk_drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| global_en | input | 1 | Global port enable |
| tx_en | input | 1 | Transmit path enabled |
| rx_en | input | 1 | Receive path enabled |
| master_mode | input | 1 | 1: generate clocks, 0: track external pins |
| mdiv_sel | input | 1 | Master-to-bit ratio, 0: 2, 1: 4 |
| frame_sel | input | 2 | Bit periods per frame, 0: 32, 1: 64, 2/3: 128 |
| bclk_invert | input | 1 | 0: launch on falling edge, 1: launch on rising edge |
| free_run | input | 1 | Keep the bit clock running without data |
| data_active | input | 1 | Serializer is moving data |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_ws | input | 1 | External word select (slave mode) |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left |
| launch_stb | output | 1 | Launch-edge strobe |
| capture_stb | output | 1 | Capture-edge strobe |
| frame_stb | output | 1 | Frame-start strobe |
| clk_drive_en | output | 1 | Output enable for the clock pins |

## Verification
Every output is a register fed from the next counter position, so a wrong divider or frame count shows in the very next cycle. It appears as a bit clock level or strobe at the wrong master-cycle index, or as a word-select change away from a launch strobe. A counter left uncleared after a stop shows on re-enable, where the first sample would miss its frame strobe or begin in the right half. In slave mode a missing or extra synchronizer stage moves the strobe one cycle from the third sample after a pin change, and that is caught at once.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef struct packed {
        logic bclk;
        logic ws;
        logic launch;
        logic capture;
        logic frame;
    } acg_evt_t;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } acg_src_e;

    // master cycles per bit period
    function automatic int unsigned mdiv_ratio(input logic sel);
        return sel ? 32'd4 : 32'd2;
    endfunction

    // bit periods per stereo frame
    function automatic int unsigned frame_ratio(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32'd32;
            2'd1:    return 32'd64;
            default: return 32'd128;
        endcase
    endfunction

    function automatic acg_evt_t idle_evt(input logic inv);
        acg_evt_t e;
        e.bclk    = ~inv;
        e.ws      = 1'b0;
        e.launch  = 1'b0;
        e.capture = 1'b0;
        e.frame   = 1'b0;
        return e;
    endfunction

endpackage

// File: rtl/acg_master_div.sv
module acg_master_div
    import acg_pkg::*;
#(
    parameter int MCNT_W = 2,
    parameter int BCNT_W = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           restart,
    input  logic           mdiv_sel,
    input  logic [1:0]     frame_sel,
    output acg_evt_t       nxt
);
    localparam int MR_W = MCNT_W + 1;
    localparam int FR_W = BCNT_W + 1;

    logic [MCNT_W-1:0] mcnt, mcnt_n;
    logic [BCNT_W-1:0] bcnt, bcnt_n;
    logic [MR_W-1:0]   mdiv;
    logic [FR_W-1:0]   nfrm;

    assign mdiv = MR_W'(mdiv_ratio(mdiv_sel));
    assign nfrm = FR_W'(frame_ratio(frame_sel));

    always_comb begin
        mcnt_n = '0;
        bcnt_n = '0;
        if (run && !restart) begin
            if ({1'b0, mcnt} >= mdiv - 1'b1) begin
                mcnt_n = '0;
                if ({1'b0, bcnt} >= nfrm - 1'b1) bcnt_n = '0;
                else                             bcnt_n = bcnt + 1'b1;
            end else begin
                mcnt_n = mcnt + 1'b1;
                bcnt_n = bcnt;
            end
        end
        nxt.bclk    = ({1'b0, mcnt_n} >= (mdiv >> 1));
        nxt.ws      = ({1'b0, bcnt_n} >= (nfrm >> 1));
        nxt.launch  = (mcnt_n == '0);
        nxt.capture = ({1'b0, mcnt_n} == (mdiv >> 1));
        nxt.frame   = (mcnt_n == '0) && (bcnt_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcnt <= '0;
            bcnt <= '0;
        end else begin
            mcnt <= mcnt_n;
            bcnt <= bcnt_n;
        end
    end

    // R5: a stopped divider holds position zero
    p_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (mcnt == '0 && bcnt == '0));

endmodule

// File: rtl/acg_slave_sync.sv
module acg_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_bclk,
    input  logic ext_ws,
    output logic sync_bclk,
    output logic sync_ws
);
    logic [STAGES-1:0] bq, wq;

    always_ff @(posedge clk) begin
        if (rst) begin
            bq <= '0;
            wq <= '0;
        end else begin
            bq[0] <= ext_bclk;
            wq[0] <= ext_ws;
            for (int i = 1; i < STAGES; i++) begin
                bq[i] <= bq[i-1];
                wq[i] <= wq[i-1];
            end
        end
    end

    assign sync_bclk = bq[STAGES-1];
    assign sync_ws   = wq[STAGES-1];

endmodule

// File: rtl/acg_clkgen.sv
module acg_clkgen
    import acg_pkg::*;
#(
    parameter int MCNT_W      = 2,
    parameter int BCNT_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       global_en,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       master_mode,
    input  logic       mdiv_sel,
    input  logic [1:0] frame_sel,
    input  logic       bclk_invert,
    input  logic       free_run,
    input  logic       data_active,
    input  logic       ext_bclk,
    input  logic       ext_ws,
    output logic       bclk_o,
    output logic       ws_o,
    output logic       launch_stb,
    output logic       capture_stb,
    output logic       frame_stb,
    output logic       clk_drive_en
);
    acg_src_e  src;
    logic      run, run_m, started, restart, gate;
    logic      s_bclk, s_ws;
    acg_evt_t  nxt, out_q;
    logic      drive_q;

    assign run     = global_en & (tx_en | rx_en);
    assign src     = master_mode ? SRC_INT : SRC_EXT;
    assign run_m   = run & (src == SRC_INT);
    assign restart = run & ~started;
    assign gate    = ~free_run & ~data_active;

    acg_master_div #(
        .MCNT_W (MCNT_W),
        .BCNT_W (BCNT_W)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (run_m),
        .restart   (restart),
        .mdiv_sel  (mdiv_sel),
        .frame_sel (frame_sel),
        .nxt       (nxt)
    );

    acg_slave_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ext_bclk  (ext_bclk),
        .ext_ws    (ext_ws),
        .sync_bclk (s_bclk),
        .sync_ws   (s_ws)
    );

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            started <= 1'b0;
            out_q   <= idle_evt(bclk_invert);
            drive_q <= 1'b0;
        end else begin
            started <= 1'b1;
            drive_q <= (src == SRC_INT);
            if (src == SRC_INT) begin
                out_q.bclk    <= gate ? ~bclk_invert : (nxt.bclk ^ bclk_invert);
                out_q.ws      <= nxt.ws;
                out_q.launch  <= nxt.launch;
                out_q.capture <= nxt.capture;
                out_q.frame   <= nxt.frame;
            end else begin
                out_q.bclk <= s_bclk;
                out_q.ws   <= s_ws;
                if (restart) begin
                    out_q.launch  <= 1'b0;
                    out_q.capture <= 1'b0;
                    out_q.frame   <= 1'b0;
                end else begin
                    out_q.launch  <= (s_bclk != out_q.bclk) && (s_bclk == bclk_invert);
                    out_q.capture <= (s_bclk != out_q.bclk) && (s_bclk != bclk_invert);
                    out_q.frame   <= ~s_ws & out_q.ws;
                end
            end
        end
    end

    assign bclk_o       = out_q.bclk;
    assign ws_o         = out_q.ws;
    assign launch_stb   = out_q.launch;
    assign capture_stb  = out_q.capture;
    assign frame_stb    = out_q.frame;
    assign clk_drive_en = drive_q;

    // R3: launch and capture edges are distinct single-cycle events
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(launch_stb && capture_stb));
    p_launch_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        launch_stb |=> !launch_stb);
    // R4: in master mode a frame start is a launch edge of the left half
    p_frame_on_launch_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && clk_drive_en) |-> (launch_stb && !ws_o));
    // R2: generated word select only moves on a launch edge
    p_ws_on_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (clk_drive_en && $past(clk_drive_en) && !$stable(ws_o)) |-> launch_stb);
    // R5: stopping parks all outputs
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!launch_stb && !capture_stb && !frame_stb && !ws_o && !clk_drive_en));
    // R7: gated bit clock sits at its idle level
    p_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (run && master_mode && !free_run && !data_active) |=> (bclk_o == !$past(bclk_invert)));
    // R9: pin drive follows master-mode running
    p_drive_r9: assert property (@(posedge clk) disable iff (rst)
        (run && master_mode) |=> clk_drive_en);

endmodule

// File: tb/acg_clkgen_tb_top.sv
`timescale 1ns/1ps
module acg_clkgen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       global_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic       master_mode = 1'b1, mdiv_sel = 1'b0;
    logic [1:0] frame_sel = 2'd0;
    logic       bclk_invert = 1'b0, free_run = 1'b1, data_active = 1'b1;
    logic       ext_bclk = 1'b1, ext_ws = 1'b1;
    logic       bclk_o, ws_o, launch_stb, capture_stb, frame_stb, clk_drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acg_clkgen dut_i (
        .clk(clk), .rst(rst), .global_en(global_en), .tx_en(tx_en), .rx_en(rx_en),
        .master_mode(master_mode), .mdiv_sel(mdiv_sel), .frame_sel(frame_sel),
        .bclk_invert(bclk_invert), .free_run(free_run), .data_active(data_active),
        .ext_bclk(ext_bclk), .ext_ws(ext_ws), .bclk_o(bclk_o), .ws_o(ws_o),
        .launch_stb(launch_stb), .capture_stb(capture_stb), .frame_stb(frame_stb),
        .clk_drive_en(clk_drive_en)
    );

    // {mdiv_sel, frame_sel, bclk_invert, cycles per bit, bits per frame}
    localparam int CFG [5][5] = '{
        '{0, 0, 0, 2, 32},
        '{1, 0, 1, 4, 32},
        '{0, 1, 1, 2, 64},
        '{1, 2, 0, 4, 128},
        '{0, 3, 1, 2, 128}
    };

    // expected {bclk, ws, launch, capture, frame} at master cycle k after start
    function automatic logic [4:0] model(input int k, input int d, input int n,
                                         input logic inv, input logic gated);
        int m, b;
        logic bc;
        m  = k % d;
        b  = (k / d) % n;
        bc = gated ? ~inv : ((m >= d / 2) ^ inv);
        return {bc, (b >= n / 2), (m == 0), (m == d / 2), (m == 0 && b == 0)};
    endfunction

    function automatic logic [4:0] obs();
        return {bclk_o, ws_o, launch_stb, capture_stb, frame_stb};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic slave_step(input logic b, input logic w, input logic [4:0] hold,
                              input logic [4:0] hit, input string req);
        ext_bclk = b;
        ext_ws   = w;
        repeat (2) begin
            @(negedge clk);
            check(req, {1'b0, obs()}, {1'b0, hold});
        end
        @(negedge clk);
        check(req, {1'b0, obs()}, {1'b0, hit});
        @(negedge clk);
        check(req, {1'b0, obs()}, {1'b0, hit & 5'b11000});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset", {obs(), clk_drive_en}, 6'b100000);
        rst = 1'b0;

        // R5: global enable alone does not start the clocks
        global_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 no tx/rx", {obs(), clk_drive_en}, 6'b100000);
        rx_en = 1'b1;
        for (int k = 0; k <= 36; k++) begin
            @(negedge clk);
            check("R5 R6 rx only", {1'b0, obs()}, {1'b0, model(k, 2, 32, 1'b0, 1'b0)});
        end
        global_en = 1'b0;
        @(negedge clk);
        check("R5 stop mid-frame", {obs(), clk_drive_en}, 6'b100000);
        global_en = 1'b1;
        @(negedge clk);
        check("R6 restart left", {obs(), clk_drive_en}, 6'b001011);
        global_en = 1'b0;
        tx_en = 1'b1;
        rx_en = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4 R9: table of ratio and polarity settings
        for (int i = 0; i < 5; i++) begin
            mdiv_sel    = CFG[i][0][0];
            frame_sel   = CFG[i][1][1:0];
            bclk_invert = CFG[i][2][0];
            @(negedge clk);
            global_en = 1'b1;
            for (int k = 0; k < 2 * CFG[i][3] * CFG[i][4]; k++) begin
                @(negedge clk);
                check("R1 R2 R3 R4", {1'b0, obs()},
                      {1'b0, model(k, CFG[i][3], CFG[i][4], CFG[i][2][0], 1'b0)});
                if (k == 0) check("R9 drive", {5'b0, clk_drive_en}, 6'b000001);
            end
            global_en = 1'b0;
            @(negedge clk);
            check("R5 idle", {obs(), clk_drive_en}, {~CFG[i][2][0], 5'b00000});
        end

        // R7: gating, released after the first frame
        mdiv_sel = 1'b0; frame_sel = 2'd0; bclk_invert = 1'b0;
        free_run = 1'b0; data_active = 1'b0;
        @(negedge clk);
        global_en = 1'b1;
        for (int k = 0; k < 128; k++) begin
            @(negedge clk);
            check("R7 gating", {1'b0, obs()}, {1'b0, model(k, 2, 32, 1'b0, (k < 64))});
            data_active = (k + 1 >= 64);
        end
        global_en = 1'b0;
        free_run = 1'b1;
        @(negedge clk);

        // R8 R9: slave tracking
        master_mode = 1'b0;
        ext_bclk = 1'b1;
        ext_ws = 1'b1;
        repeat (3) @(negedge clk);
        global_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 R9 slave settled", {obs(), clk_drive_en}, 6'b110000);
        slave_step(1'b0, 1'b1, 5'b11000, 5'b01100, "R8 falling launch");
        slave_step(1'b1, 1'b1, 5'b01000, 5'b11010, "R8 rising capture");
        slave_step(1'b0, 1'b0, 5'b11000, 5'b00101, "R8 ws fall frame");
        bclk_invert = 1'b1;
        slave_step(1'b1, 1'b0, 5'b00000, 5'b10100, "R8 R3 rising launch");
        global_en = 1'b0;
        @(negedge clk);
        check("R5 slave stop", {obs(), clk_drive_en}, 6'b000000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule